// File: doc/BRIEF.md
# Occupancy Range Indicator with Flashing Alert

This block turns the tens digit of a parking occupancy count into three kinds of status light: a green "plenty of room" light, a yellow "filling up" light and a pair of red alert lights that blink. The digit arrives in BCD. Only its two least significant bits choose the range, so the lights hold steady while the ones digit moves within a band of ten.

The red pair does not light steadily. A divider inside the block counts a programmable number of clock cycles per half period and produces a 50% duty blink. The blink runs only while the digit is in the alert band and the flash enable input is high. When the blink stops, its phase returns to the dark state, so every new alert episode begins with a full dark half period. The fourth combination of the two decoded bits lights nothing.

All outputs come from registers and follow the inputs by one clock.

Top module: `occ_range_indicator`

## Requirements
- R1: Only `tens_bcd[1:0]` selects the range. Bits `tens_bcd[3:2]` have no effect on any output.
- R2: When `tens_bcd[1:0]` is 2'b00, `led_green` is high and `led_yellow` and both red outputs are low.
- R3: When `tens_bcd[1:0]` is 2'b01, `led_yellow` is high and `led_green` and both red outputs are low.
- R4: When `tens_bcd[1:0]` is 2'b10 and `flash_en` is high, green and yellow are low. The red outputs stay low for HALF_CYC clocks, then high for HALF_CYC clocks, and keep alternating in this way.
- R5: When `tens_bcd[1:0]` is 2'b11, every output is low.
- R6: `led_red_a` and `led_red_b` are equal at every clock.
- R7: When `flash_en` is low, or the digit leaves the 2'b10 band, the red outputs go low on the next clock. The next alert episode starts again with a full low half period.
- R8: While `rst_n` is low, all outputs are low after a clock edge.
- R9: Every output reflects the inputs that were present at the previous rising clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| tens_bcd | input | 4 | BCD tens digit of the occupancy count |
| flash_en | input | 1 | Allows the red blink when high |
| led_green | output | 1 | Safe-range indicator |
| led_yellow | output | 1 | Warning-range indicator |
| led_red_a | output | 1 | First red alert indicator |
| led_red_b | output | 1 | Second red alert indicator, equal to the first |

## Verification
The bench builds the block with HALF_CYC set to 3. With this value, many complete blink periods fit in a short run, so phase restarts after a disable or after leaving the band can be seen, as well as re-entry in the middle of a half period. The bench drives every tens value from 0 to 15, so each of the four range codes occurs with the upper bits both clear and set.

// File: rtl/occ_ind_pkg.sv
package occ_ind_pkg;

  typedef enum logic [1:0] {
    ZONE_SAFE  = 2'b00,
    ZONE_WARN  = 2'b01,
    ZONE_ALERT = 2'b10,
    ZONE_DARK  = 2'b11
  } zone_e;

  // Range code from the two low bits of the tens digit.
  function automatic zone_e zone_of(input logic [1:0] low_bits);
    return zone_e'(low_bits);
  endfunction

  // True on the last cycle of a half period.
  function automatic logic half_done(input int unsigned cnt, input int unsigned half);
    return (cnt + 1) >= half;
  endfunction

endpackage

// File: rtl/occ_zone_decode.sv
module occ_zone_decode
  import occ_ind_pkg::*;
#(
  parameter int DIGIT_W = 4
) (
  input  logic [DIGIT_W-1:0] digit,
  output zone_e              zone,
  output logic               is_safe,
  output logic               is_warn,
  output logic               is_alert
);

  assign zone     = zone_of(digit[1:0]);
  assign is_safe  = (zone == ZONE_SAFE);
  assign is_warn  = (zone == ZONE_WARN);
  assign is_alert = (zone == ZONE_ALERT);

endmodule

// File: rtl/occ_flash_gen.sv
module occ_flash_gen
  import occ_ind_pkg::*;
#(
  parameter int HALF_CYC = 25_000_000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic blink
);

  localparam int CNT_W = (HALF_CYC > 1) ? $clog2(HALF_CYC) : 1;

  logic [CNT_W-1:0] cnt_q;
  logic             phase_q;
  logic             wrap;

  assign wrap  = half_done(int'(cnt_q), HALF_CYC);
  assign blink = phase_q;

  always_ff @(posedge clk) begin
    if (!rst_n || !run) begin
      cnt_q   <= '0;
      phase_q <= 1'b0;
    end else if (wrap) begin
      cnt_q   <= '0;
      phase_q <= ~phase_q;
    end else begin
      cnt_q   <= cnt_q + 1'b1;
    end
  end

  // R4: the phase changes only when a half period ends
  a_r4_hold_phase: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !wrap) |=> $stable(phase_q));

  // R4: at the end of a half period the phase inverts
  a_r4_flip_phase: assert property (@(posedge clk) disable iff (!rst_n)
    (run && wrap) |=> (phase_q != $past(phase_q)));

  // R7: a stop clears the blink and the phase counter
  a_r7_restart: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (!phase_q && cnt_q == '0));

endmodule

// File: rtl/occ_range_indicator.sv
module occ_range_indicator
  import occ_ind_pkg::*;
#(
  parameter int HALF_CYC = 25_000_000,
  parameter int DIGIT_W  = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [DIGIT_W-1:0] tens_bcd,
  input  logic               flash_en,
  output logic               led_green,
  output logic               led_yellow,
  output logic               led_red_a,
  output logic               led_red_b
);

  zone_e zone;
  logic  is_safe, is_warn, is_alert;
  logic  blink_run;
  logic  blink;
  logic  green_q, yellow_q;

  occ_zone_decode #(.DIGIT_W(DIGIT_W)) u_dec (
    .digit    (tens_bcd),
    .zone     (zone),
    .is_safe  (is_safe),
    .is_warn  (is_warn),
    .is_alert (is_alert)
  );

  assign blink_run = is_alert && flash_en;

  occ_flash_gen #(.HALF_CYC(HALF_CYC)) u_flash (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (blink_run),
    .blink (blink)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      green_q  <= 1'b0;
      yellow_q <= 1'b0;
    end else begin
      green_q  <= is_safe;
      yellow_q <= is_warn;
    end
  end

  assign led_green  = green_q;
  assign led_yellow = yellow_q;
  assign led_red_a  = blink;
  assign led_red_b  = blink;

  // R2: safe code lights green only
  a_r2_green_only: assert property (@(posedge clk) disable iff (!rst_n)
    (tens_bcd[1:0] == 2'b00) |=> (led_green && !led_yellow && !led_red_a));

  // R3: warning code lights yellow only
  a_r3_yellow_only: assert property (@(posedge clk) disable iff (!rst_n)
    (tens_bcd[1:0] == 2'b01) |=> (!led_green && led_yellow && !led_red_a));

  // R5: unused code keeps every light dark
  a_r5_all_dark: assert property (@(posedge clk) disable iff (!rst_n)
    (tens_bcd[1:0] == 2'b11) |=> !(led_green || led_yellow || led_red_a || led_red_b));

  // R7: disabled flashing forces red low
  a_r7_red_off: assert property (@(posedge clk) disable iff (!rst_n)
    !flash_en |=> !(led_red_a || led_red_b));

  // R6: the red pair never disagrees
  a_r6_red_pair: assert property (@(posedge clk) disable iff (!rst_n)
    led_red_a == led_red_b);

  // R4: the alert band never lights green or yellow
  a_r4_no_steady: assert property (@(posedge clk) disable iff (!rst_n)
    (tens_bcd[1:0] == 2'b10) |=> !(led_green || led_yellow));

endmodule

// File: tb/sim_occ_range_indicator.sv
`timescale 1ns/1ps
module sim_occ_range_indicator;

  localparam int HALF = 3;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] tens_bcd = 4'd0;
  logic       flash_en = 1'b0;
  logic       led_green, led_yellow, led_red_a, led_red_b;

  int tests = 0;
  int fails = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  occ_range_indicator #(.HALF_CYC(HALF), .DIGIT_W(4)) u0 (
    .clk(clk), .rst_n(rst_n), .tens_bcd(tens_bcd), .flash_en(flash_en),
    .led_green(led_green), .led_yellow(led_yellow),
    .led_red_a(led_red_a), .led_red_b(led_red_b)
  );

  // Behavioural reference model, advanced on each rising edge
  int  run_len = 0;
  bit  exp_g = 0, exp_y = 0, exp_r = 0;
  int  prev_code = 0, prev_hi = 0;
  bit  prev_en = 0, prev_rst = 1;
  bit  armed = 0;

  always @(posedge clk) begin
    prev_code = int'(tens_bcd) % 4;
    prev_hi   = int'(tens_bcd) / 4;
    prev_en   = flash_en;
    prev_rst  = !rst_n;
    if (!rst_n) begin
      run_len = 0; exp_g = 0; exp_y = 0; exp_r = 0;
    end else begin
      exp_g = (prev_code == 0);
      exp_y = (prev_code == 1);
      if (prev_code == 2 && flash_en) begin
        run_len = run_len + 1;
        exp_r = ((run_len / HALF) % 2) == 1;
      end else begin
        run_len = 0;
        exp_r = 0;
      end
    end
    armed = 1;
  end

  task automatic check(input string req, input string what, input logic act, input logic exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual=%b expected=%b at %0t", req, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (armed && !done) begin
      string tg;
      if (prev_rst) tg = "R8";
      else if (prev_hi != 0) tg = "R1";
      else if (prev_code == 3) tg = "R5";
      else if (prev_code == 0) tg = "R2";
      else if (prev_code == 1) tg = "R3";
      else if (!prev_en) tg = "R7";
      else tg = "R4";
      check(tg, "green", led_green, exp_g);
      check(tg, "yellow", led_yellow, exp_y);
      check(tg, "red_a", led_red_a, exp_r);
      check("R6", "red_b", led_red_b, led_red_a);
      check("R9", "red_b model", led_red_b, exp_r);
    end
  end

  task automatic hold(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    hold(3);
    rst_n = 1'b1;
    flash_en = 1'b1;
    // Walk every tens value, both with and without the upper bits
    for (int v = 0; v < 16; v++) begin
      tens_bcd = 4'(v);
      hold((v % 4 == 2) ? 4 * HALF + 1 : 3);
    end
    // R4 long blink, then R7 disable and re-enable in the middle
    tens_bcd = 4'd2;
    hold(5 * HALF);
    flash_en = 1'b0;
    hold(4);
    flash_en = 1'b1;
    hold(2 * HALF + 1);
    flash_en = 1'b0;
    hold(1);
    flash_en = 1'b1;
    hold(3 * HALF);
    // R7 leave the band and return briefly
    tens_bcd = 4'd1;
    hold(1);
    tens_bcd = 4'd2;
    hold(2 * HALF + 2);
    tens_bcd = 4'd3;
    hold(2);
    tens_bcd = 4'd6;
    hold(4 * HALF);
    // R8 reset in the middle of a blink
    rst_n = 1'b0;
    hold(3);
    rst_n = 1'b1;
    hold(3 * HALF);
    // R1 upper bits toggle inside the alert band
    for (int k = 0; k < 4 * HALF; k++) begin
      tens_bcd = {2'(k), 2'b10};
      hold(1);
    end
    tens_bcd = 4'd0;
    flash_en = 1'b0;
    hold(3);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      done = 1'b1;
      tests++;
      fails++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

endmodule